// File: doc/BRIEF.md
# Stereo Audio Transmit FIFO with Drain-Count Interrupt

This block sits between a processor and the serializer of an audio serial output channel. Software pushes one left/right sample pair per write. The serializer pops one pair per output frame. Four pairs are buffered in between. Each pair carries two 24-bit samples. A narrow-sample option takes 16-bit samples from the write data and left-justifies them inside the 24-bit slot.

To ask for a refill, the block counts the pairs it has handed to the serializer since the last request. The interrupt mode sets how many pops are needed: one pop, half the depth, or the whole depth. When that count is reached, a sticky pending flag is set. The flag stays set until software acknowledges it. The interrupt output is the pending flag, gated by an enable input. Software can also read the fill level, the empty and full flags, and sticky overflow and underflow flags.

Top module: `audio_tx_fifo`

## Requirements
- R1: While synchronous reset is high, and in the first cycle after it, these hold: level = 0, `empty` = 1, `full` = 0, `pending` = 0, `irq` = 0, `overflow` = 0, `underflow` = 0, and both popped samples are zero. The internal mode state starts at code 0.
- R2: Accepted pairs come out of `pop_left`/`pop_right` in write order. The data appears in the cycle after the pop. `level` counts the stored pairs (0 to DEPTH). `empty` is high exactly when level is 0. `full` is high exactly when level equals DEPTH.
- R3: A write while `full` is high is dropped. It changes neither the stored data nor the level, and it sets the sticky `overflow` flag.
- R4: A pop while `empty` is high keeps the previous popped data on the outputs and sets the sticky `underflow` flag. It does not count as a drained pair.
- R5: In a cycle with an accepted write and an accepted pop, the level stays the same.
- R6: When `half_width` is 1 at the write, each stored sample is the write data's bits [15:0] in bits [23:8], with bits [7:0] zero. When it is 0, all 24 bits are stored unchanged.
- R7: With `mode_sel` = 0 (half mode), `pending` is set on the second accepted pop counted since the last request.
- R8: With `mode_sel` = 1 (whole mode), `pending` is set on the fourth (DEPTH-th) counted pop. If the FIFO was filled in one burst, it is empty at that moment.
- R9: With `mode_sel` = 2 (single mode), `pending` is set on every accepted pop.
- R10: With `mode_sel` = 3 (reserved), `pending` is never set.
- R11: `pending` is sticky. It is cleared by `irq_ack` = 1. If a new request and an acknowledge fall in the same cycle, the request wins. `irq` equals `pending` AND `irq_en`.
- R12: In a cycle where `mode_sel` differs from its value in the previous cycle, the drained-pair count is reset to zero and that cycle's pop is not counted.
- R13: `err_ack` = 1 clears `overflow` and `underflow`. A new error event in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Push one stereo pair |
| wr_left | input | 24 | Left sample to push |
| wr_right | input | 24 | Right sample to push |
| half_width | input | 1 | 1 = 16-bit samples, left-justified on write |
| mode_sel | input | 2 | Interrupt timing: 0 half, 1 whole, 2 single, 3 reserved |
| irq_en | input | 1 | Interrupt enable |
| irq_ack | input | 1 | Write-one clear of the pending flag |
| err_ack | input | 1 | Write-one clear of the overflow and underflow flags |
| pop | input | 1 | Serializer frame strobe, pops one pair |
| pop_left | output | 24 | Left sample of the last popped pair |
| pop_right | output | 24 | Right sample of the last popped pair |
| level | output | 3 | Number of stored pairs |
| empty | output | 1 | FIFO holds no pairs |
| full | output | 1 | FIFO holds DEPTH pairs |
| pending | output | 1 | Sticky refill request |
| irq | output | 1 | Interrupt request |
| overflow | output | 1 | Sticky dropped-write flag |
| underflow | output | 1 | Sticky empty-pop flag |

## Verification
The bench builds the block with its default DEPTH of 4. At that depth, the half threshold is 2 and the whole threshold is 4. Every interrupt mode can be swept, including the reserved code, in both sample widths and with the enable both low and high. The small depth also lets short bursts reach the full and empty edges. A burst of five writes causes an overflow, and a run of five pops causes an underflow. Interleaved push-and-pop runs, acknowledges that land on the same cycle as a request, and a mid-stream mode change are all checked against an arithmetic model of the queue, the drain counter and the flags.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    localparam int SAMPLE_W = 24;
    localparam int NARROW_W = 16;
    localparam int PAD_W    = SAMPLE_W - NARROW_W;

    typedef logic [SAMPLE_W-1:0] sample_t;

    typedef struct packed {
        sample_t left;
        sample_t right;
    } pair_t;

    typedef enum logic [1:0] {
        DRAIN_HALF   = 2'd0,
        DRAIN_WHOLE  = 2'd1,
        DRAIN_SINGLE = 2'd2,
        DRAIN_NONE   = 2'd3
    } drain_mode_e;

    // Left-justify a narrow sample inside the full-width slot.
    function automatic sample_t fit_sample(input sample_t raw, input logic narrow);
        if (narrow)
            return {raw[NARROW_W-1:0], {PAD_W{1'b0}}};
        return raw;
    endfunction

    // Number of pops that raise a request; zero means never.
    function automatic int drain_target(input drain_mode_e m, input int depth);
        case (m)
            DRAIN_HALF:   return depth / 2;
            DRAIN_WHOLE:  return depth;
            DRAIN_SINGLE: return 1;
            default:      return 0;
        endcase
    endfunction

endpackage

// File: rtl/audtx_pack.sv
module audtx_pack
    import audtx_pkg::*;
(
    input  sample_t in_left,
    input  sample_t in_right,
    input  logic    narrow,
    output pair_t   packed_pair
);
    localparam int LANES = 2;

    sample_t lane_in  [LANES];
    sample_t lane_out [LANES];

    assign lane_in[0] = in_left;
    assign lane_in[1] = in_right;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_out[g] = fit_sample(lane_in[g], narrow);
    end

    assign packed_pair.left  = lane_out[0];
    assign packed_pair.right = lane_out[1];

endmodule

// File: rtl/audtx_store.sv
module audtx_store
    import audtx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pull,
    input  pair_t            wdata,
    output pair_t            head,
    output logic [LVL_W-1:0] count,
    output logic             is_empty,
    output logic             is_full
);
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] CAP      = LVL_W'(DEPTH);

    pair_t            slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                slot[i] <= '0;
        end else if (push) begin
            slot[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push)
                wr_ptr <= bump(wr_ptr);
            if (pull)
                rd_ptr <= bump(rd_ptr);
            case ({push, pull})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head     = slot[rd_ptr];
    assign is_empty = (count == '0);
    assign is_full  = (count == CAP);

endmodule

// File: rtl/audtx_drain.sv
module audtx_drain
    import audtx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  drain_mode_e mode,
    input  logic        pulled,
    input  logic        ack,
    output logic        req
);
    drain_mode_e      mode_q;
    logic [CNT_W-1:0] drained;
    logic             mode_moved;
    logic             counting;
    logic             hit;
    int               target;

    always_comb begin
        target     = drain_target(mode, DEPTH);
        mode_moved = (mode != mode_q);
        counting   = pulled && !mode_moved && (target != 0);
        hit        = counting && ((int'(drained) + 1) == target);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= DRAIN_HALF;
            drained <= '0;
            req     <= 1'b0;
        end else begin
            mode_q <= mode;
            if (mode_moved || hit)
                drained <= '0;
            else if (counting)
                drained <= drained + 1'b1;
            if (hit)
                req <= 1'b1;
            else if (ack)
                req <= 1'b0;
        end
    end

endmodule

// File: rtl/audio_tx_fifo.sv
module audio_tx_fifo
    import audtx_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_left,
    input  logic [SAMPLE_W-1:0] wr_right,
    input  logic                half_width,
    input  logic [1:0]          mode_sel,
    input  logic                irq_en,
    input  logic                irq_ack,
    input  logic                err_ack,
    input  logic                pop,
    output logic [SAMPLE_W-1:0] pop_left,
    output logic [SAMPLE_W-1:0] pop_right,
    output logic [LVL_W-1:0]    level,
    output logic                empty,
    output logic                full,
    output logic                pending,
    output logic                irq,
    output logic                overflow,
    output logic                underflow
);
    pair_t in_pair;
    pair_t head_pair;
    pair_t out_pair;
    logic  push_ok;
    logic  pull_ok;

    audtx_pack u_pack (
        .in_left     (wr_left),
        .in_right    (wr_right),
        .narrow      (half_width),
        .packed_pair (in_pair)
    );

    assign push_ok = wr_en && !full;
    assign pull_ok = pop && !empty;

    audtx_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (push_ok),
        .pull     (pull_ok),
        .wdata    (in_pair),
        .head     (head_pair),
        .count    (level),
        .is_empty (empty),
        .is_full  (full)
    );

    audtx_drain #(.DEPTH(DEPTH)) u_drain (
        .clk    (clk),
        .rst    (rst),
        .mode   (drain_mode_e'(mode_sel)),
        .pulled (pull_ok),
        .ack    (irq_ack),
        .req    (pending)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_pair  <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (pull_ok)
                out_pair <= head_pair;
            if (wr_en && full)
                overflow <= 1'b1;
            else if (err_ack)
                overflow <= 1'b0;
            if (pop && empty)
                underflow <= 1'b1;
            else if (err_ack)
                underflow <= 1'b0;
        end
    end

    assign pop_left  = out_pair.left;
    assign pop_right = out_pair.right;
    assign irq       = pending && irq_en;

endmodule

// File: rtl/audio_tx_fifo_checker.sv
module audio_tx_fifo_checker #(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_en,
    input logic             pop,
    input logic [1:0]       mode_sel,
    input logic             irq_ack,
    input logic [23:0]      pop_left,
    input logic [23:0]      pop_right,
    input logic [LVL_W-1:0] level,
    input logic             empty,
    input logic             full,
    input logic             pending,
    input logic             overflow,
    input logic             underflow
);
    // R1: reset clears level and request
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (level == '0) && !pending && !overflow && !underflow);

    // R2: never full and empty together
    a_r2_not_full_and_empty: assert property (@(posedge clk) disable iff (rst)
        !(full && empty));

    // R3: dropped write keeps level at capacity and flags overflow
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (full && wr_en && !pop) |=> (level == LVL_W'(DEPTH)) && overflow);

    // R4: empty pop holds data and flags underflow
    a_r4_underflow_holds: assert property (@(posedge clk) disable iff (rst)
        (empty && pop) |=> underflow && $stable(pop_left) && $stable(pop_right));

    // R5: simultaneous accepted push and pop leave level unchanged
    a_r5_level_steady: assert property (@(posedge clk) disable iff (rst)
        (wr_en && pop && !empty && !full) |=> $stable(level));

    // R9: single mode requests on each accepted pop
    a_r9_single_each_pop: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd2 && $past(mode_sel) == 2'd2 && !$past(rst) && pop && !empty)
        |=> pending);

    // R10: reserved mode never raises a request
    a_r10_reserved_silent: assert property (@(posedge clk) disable iff (rst)
        (mode_sel == 2'd3 && !pending) |=> !pending);

    // R11: request stays until acknowledged
    a_r11_pending_sticky: assert property (@(posedge clk) disable iff (rst)
        (pending && !irq_ack) |=> pending);

endmodule

bind audio_tx_fifo audio_tx_fifo_checker #(.DEPTH(DEPTH)) u_checker (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .pop       (pop),
    .mode_sel  (mode_sel),
    .irq_ack   (irq_ack),
    .pop_left  (pop_left),
    .pop_right (pop_right),
    .level     (level),
    .empty     (empty),
    .full      (full),
    .pending   (pending),
    .overflow  (overflow),
    .underflow (underflow)
);

// File: tb/audio_tx_fifo_bench.sv
module audio_tx_fifo_bench;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0, pop = 1'b0, irq_ack = 1'b0, err_ack = 1'b0;
    logic        half_width = 1'b0, irq_en = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic [23:0] wr_left = '0, wr_right = '0;
    logic [23:0] pop_left, pop_right;
    logic [2:0]  level;
    logic        empty, full, pending, irq, overflow, underflow;

    always #5 clk = ~clk;

    audio_tx_fifo #(.DEPTH(DEPTH)) u_audio_tx_fifo (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_left(wr_left), .wr_right(wr_right),
        .half_width(half_width), .mode_sel(mode_sel), .irq_en(irq_en),
        .irq_ack(irq_ack), .err_ack(err_ack), .pop(pop),
        .pop_left(pop_left), .pop_right(pop_right), .level(level),
        .empty(empty), .full(full), .pending(pending), .irq(irq),
        .overflow(overflow), .underflow(underflow)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    int k = 0;

    // bench model state
    logic [23:0] ql [DEPTH];
    logic [23:0] qr [DEPTH];
    int          qn = 0;
    logic [23:0] el = '0, er = '0;
    logic        ep = 0, eo = 0, eu = 0;
    int          dc = 0;
    logic [1:0]  pm = 2'd0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic string pend_tag(input logic [1:0] m);
        case (m)
            2'd0: return "R7";
            2'd1: return "R8";
            2'd2: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int target_of(input logic [1:0] m);
        case (m)
            2'd0: return DEPTH / 2;
            2'd1: return DEPTH;
            2'd2: return 1;
            default: return 0;
        endcase
    endfunction

    function automatic logic [23:0] fit(input logic [23:0] v, input logic n);
        return n ? {v[15:0], 8'h00} : v;
    endfunction

    task automatic step(input logic wr, input logic pp, input logic ack, input logic eack);
        logic [23:0] nl, nr;
        logic        fullm, emptym, push_ok, pop_ok, hit;
        nl = 24'(32'hA31C07 + k * 32'h0135F3);
        nr = 24'(32'h4E6D21 ^ (k * 32'h02A4B9));
        k++;
        @(negedge clk);
        wr_en = wr; pop = pp; irq_ack = ack; err_ack = eack;
        wr_left = nl; wr_right = nr;
        // model
        fullm   = (qn == DEPTH);
        emptym  = (qn == 0);
        push_ok = wr && !fullm;
        pop_ok  = pp && !emptym;
        if (pop_ok) begin
            el = ql[0]; er = qr[0];
            for (int i = 0; i < DEPTH - 1; i++) begin
                ql[i] = ql[i+1]; qr[i] = qr[i+1];
            end
            qn--;
        end
        if (push_ok) begin
            ql[qn] = fit(nl, half_width); qr[qn] = fit(nr, half_width);
            qn++;
        end
        if (wr && fullm) eo = 1; else if (eack) eo = 0;
        if (pp && emptym) eu = 1; else if (eack) eu = 0;
        hit = 0;
        if (mode_sel != pm) dc = 0;
        else if (pop_ok && target_of(mode_sel) != 0) begin
            if (dc + 1 == target_of(mode_sel)) begin hit = 1; dc = 0; end
            else dc++;
        end
        if (hit) ep = 1; else if (ack) ep = 0;
        pm = mode_sel;
        @(posedge clk);
        #1;
        chk("R2", "level", 32'(level), 32'(qn));
        chk("R2", "empty", 32'(empty), 32'(qn == 0));
        chk("R2", "full", 32'(full), 32'(qn == DEPTH));
        chk(half_width ? "R6" : "R2", "pop_left", 32'(pop_left), 32'(el));
        chk(half_width ? "R6" : "R2", "pop_right", 32'(pop_right), 32'(er));
        chk(pend_tag(mode_sel), "pending", 32'(pending), 32'(ep));
        chk("R11", "irq", 32'(irq), 32'(ep && irq_en));
        chk("R3", "overflow", 32'(overflow), 32'(eo));
        chk("R4", "underflow", 32'(underflow), 32'(eu));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: state during reset
        chk("R1", "level", 32'(level), 0);
        chk("R1", "empty", 32'(empty), 1);
        chk("R1", "full", 32'(full), 0);
        chk("R1", "pending", 32'(pending), 0);
        chk("R1", "irq", 32'(irq), 0);
        chk("R1", "flags", 32'({overflow, underflow}), 0);
        chk("R1", "data", 32'(pop_left | pop_right), 0);
        @(negedge clk);
        rst = 0;

        for (int m = 0; m < 4; m++) begin
            for (int n = 0; n < 2; n++) begin
                mode_sel = 2'(m); half_width = 1'(n); irq_en = 1'(n);
                step(0, 0, 1, 1);
                for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 0);
                for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, 0);
                step(0, 0, 1, 1);
                step(1, 0, 0, 0);
                step(1, 0, 0, 0);
                for (int i = 0; i < 3; i++) begin
                    step(1, 1, 0, 0);
                    chk("R5", "level under push+pop", 32'(level), 2);
                end
                for (int i = 0; i < 3; i++) step(0, 1, 0, 0);
            end
        end

        // R11: request and acknowledge in the same cycle, request wins
        mode_sel = 2'd2; irq_en = 1; half_width = 0;
        step(0, 0, 1, 1);
        step(1, 0, 0, 0);
        step(0, 1, 1, 0);
        chk("R11", "set beats ack", 32'({pending, irq}), 32'b11);
        step(0, 0, 1, 0);
        chk("R11", "ack clears", 32'({pending, irq}), 0);

        // R12: mode change resets the drained count
        mode_sel = 2'd1;
        step(0, 0, 1, 1);
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        step(0, 1, 0, 0);
        mode_sel = 2'd0;
        step(0, 1, 0, 0);
        chk("R12", "pop in change cycle uncounted", 32'(pending), 0);
        step(0, 1, 0, 0);
        chk("R12", "first pop after change", 32'(pending), 0);
        step(1, 0, 0, 0);
        step(0, 1, 0, 0);
        chk("R12", "second pop after change", 32'(pending), 1);

        // R13: error flags clear on acknowledge; same-cycle event wins
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 0);
        chk("R13", "overflow set", 32'(overflow), 1);
        step(1, 0, 0, 1);
        chk("R13", "event beats clear", 32'(overflow), 1);
        step(0, 0, 0, 1);
        chk("R13", "cleared", 32'({overflow, underflow}), 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule